// File: doc/BRIEF.md
# Six-Channel Silence Auto-Mute

This block decides, frame by frame, which of six audio output channels are silenced before they reach the converters. Each frame strobe carries six signed PCM samples. The block registers the frame and passes it through, or replaces a channel with zero and raises that channel's mute status. Outputs change only on a strobe, except for the clock-error mute and the auto-mute enable, which act at once.

There are three ways a channel can be silenced.

- **Automatic mute.** A long unbroken run of frames in which every channel carries a silent code mutes all six outputs. Any single active sample undoes it.
- **Requested mute.** A software request is applied to each channel separately. It waits for that channel's next zero crossing, or for a fixed timeout, so that the change is free of clicks. Releasing the request follows the same rule.
- **Clock error.** A clock-recovery fault overrides both and silences everything at once.

Top module: `zm_automute_top`

## Requirements
- R1: A sample counts as silent when its bits are all zero (value 0) or all one (value -1). Any other code is active.
- R2: A frame is silent only when all six channels hold silent samples. One active channel in a frame breaks the silent run.
- R3: While auto-mute is enabled, the strobe of the 512th consecutive silent frame mutes all six channels (mute_stat = 6'h3F, outputs 0). After 511 such frames no channel is muted.
- R4: The first frame with any active sample clears the automatic mute on that same strobe and outputs its samples. A fresh run of 512 silent frames is then needed to mute again.
- R5: While auto_en is low, silent runs never mute. The enable acts combinationally on the current run count, so raising it after a run of at least 512 silent frames mutes at once, and lowering it unmutes at once.
- R6: While clk_err is high, every mute_stat bit is 1 and every output is 0 in the same cycle, with no strobe needed. Dropping clk_err restores the previous state.
- R7: A change of mute_req is applied to a channel on the first strobe at which that channel's sample is exactly 0, or its sign bit (bit W-1) differs from the sign bit of the channel's previous sample.
- R8: If no crossing occurs, a pending change is applied on the 1024th strobe at which it is pending. It is not applied on the 1023rd.
- R9: Releasing a requested mute obeys the same crossing-or-timeout rule as applying one.
- R10: The channel mute status is the OR of the automatic mute, the applied request and clk_err. A muted channel outputs 0. An unmuted channel outputs the sample taken at the last strobe.
- R11: Synchronous active-high reset clears all samples, counters and applied mutes, so mute_stat = 0 and outputs are 0. Between strobes, changes of mute_req alter nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe marking a new frame on samp_in |
| samp_in | input | NCH*W | Six signed samples, channel i at bits [i*W +: W] |
| mute_req | input | 1 | Software mute request (1 = mute) |
| auto_en | input | 1 | Enables the silence-run automatic mute |
| clk_err | input | 1 | Clock-recovery error; forces immediate full mute |
| samp_out | output | NCH*W | Samples after muting, same layout as samp_in |
| mute_stat | output | NCH | Per-channel effective mute status |

## Verification
The ending of an automatic mute and the release of a requested mute at a zero crossing can fall on the same strobe. To provoke this, the bench builds a 512-frame run of zeros while a mute request is applied on every channel. It then drops the request and sends one active frame in which only channel 0 swings negative. It judges that the auto-mute clears on all channels and channel 0 alone is released, while channels 1 to 5 stay muted by their still-pending requests.

// File: rtl/zm_pkg.sv
package zm_pkg;
  // True when the low w bits of v are all zero or all one.
  function automatic logic samp_silent(input logic [63:0] v, input int w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return ((v & mask) == 64'd0) || ((v & mask) == mask);
  endfunction

  // Zero crossing: sign flipped since the previous sample, or sample is exactly zero.
  function automatic logic is_crossing(input logic prev_sign, input logic cur_sign,
                                       input logic is_zero);
    return (prev_sign != cur_sign) || is_zero;
  endfunction
endpackage

// File: rtl/zm_silence_run.sv
module zm_silence_run #(
  parameter int NCH     = 6,
  parameter int W       = 24,
  parameter int RUN_LEN = 512
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_stb,
  input  logic [NCH*W-1:0] frame_in,
  input  logic           auto_en,
  output logic           auto_mute
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [NCH-1:0] ch_silent;
  logic           frame_silent;
  logic [CW-1:0]  run_q;

  for (genvar g = 0; g < NCH; g++) begin : g_sil
    assign ch_silent[g] = zm_pkg::samp_silent(64'(frame_in[g*W +: W]), W);
  end
  assign frame_silent = &ch_silent;

  always_ff @(posedge clk) begin
    if (rst)                run_q <= '0;
    else if (frame_stb) begin
      if (!frame_silent)    run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + CW'(1);
    end
  end

  assign auto_mute = auto_en & (run_q == RUN_MAX);

  always @(posedge clk) begin
    if (!rst) a_r3_run_bounded: assert (run_q <= RUN_MAX);
  end

  a_r4_active_clears_run: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !frame_silent) |=> (run_q == '0));

  a_r3_silent_counts_up: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && frame_silent && run_q != RUN_MAX) |=> (run_q == $past(run_q) + CW'(1)));
endmodule

// File: rtl/zm_req_gate.sv
module zm_req_gate #(
  parameter int W       = 24,
  parameter int TIMEOUT = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_stb,
  input  logic [W-1:0] samp,
  input  logic         mute_req,
  output logic         applied
);
  localparam int TW = $clog2(TIMEOUT);
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT - 1);

  logic          sign_q;
  logic          applied_q;
  logic [TW-1:0] tmo_q;
  logic          pending;
  logic          crossing;
  logic          tmo_hit;

  assign pending  = (mute_req != applied_q);
  assign crossing = zm_pkg::is_crossing(sign_q, samp[W-1], samp == '0);
  assign tmo_hit  = (tmo_q == TMO_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q    <= 1'b0;
      applied_q <= 1'b0;
      tmo_q     <= '0;
    end else if (frame_stb) begin
      sign_q <= samp[W-1];
      if (pending) begin
        if (crossing || tmo_hit) begin
          applied_q <= mute_req;
          tmo_q     <= '0;
        end else begin
          tmo_q <= tmo_q + TW'(1);
        end
      end else begin
        tmo_q <= '0;
      end
    end
  end

  assign applied = applied_q;

  a_r11_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(applied_q));

  a_r7_apply_on_crossing: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && pending && crossing) |=> (applied_q == $past(mute_req)));

  a_r8_wait_without_crossing: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && pending && !crossing && !tmo_hit) |=> $stable(applied_q));
endmodule

// File: rtl/zm_automute_top.sv
module zm_automute_top #(
  parameter int NCH     = 6,
  parameter int W       = 24,
  parameter int RUN_LEN = 512,
  parameter int TIMEOUT = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic [NCH*W-1:0] samp_in,
  input  logic             mute_req,
  input  logic             auto_en,
  input  logic             clk_err,
  output logic [NCH*W-1:0] samp_out,
  output logic [NCH-1:0]   mute_stat
);
  logic [NCH*W-1:0] samp_q;
  logic             auto_mute;
  logic [NCH-1:0]   req_applied;

  always_ff @(posedge clk) begin
    if (rst)            samp_q <= '0;
    else if (frame_stb) samp_q <= samp_in;
  end

  zm_silence_run #(.NCH(NCH), .W(W), .RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .frame_in(samp_in),
    .auto_en(auto_en), .auto_mute(auto_mute)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    zm_req_gate #(.W(W), .TIMEOUT(TIMEOUT)) u_gate (
      .clk(clk), .rst(rst), .frame_stb(frame_stb), .samp(samp_in[g*W +: W]),
      .mute_req(mute_req), .applied(req_applied[g])
    );
    assign mute_stat[g]          = auto_mute | req_applied[g] | clk_err;
    assign samp_out[g*W +: W]    = mute_stat[g] ? '0 : samp_q[g*W +: W];

    a_r10_muted_is_zero: assert property (@(posedge clk) disable iff (rst)
      mute_stat[g] |-> (samp_out[g*W +: W] == '0));
  end

  a_r6_error_mutes_all: assert property (@(posedge clk) disable iff (rst)
    clk_err |-> (&mute_stat));

  a_r3_auto_mutes_all: assert property (@(posedge clk) disable iff (rst)
    auto_mute |-> (&mute_stat));
endmodule

// File: tb/sim_zm_automute_top.sv
module sim_zm_automute_top;
  localparam int NCH = 6;
  localparam int W   = 24;
  typedef logic [NCH*W-1:0] frame_t;

  logic clk = 1'b0;
  logic rst, frame_stb, mute_req, auto_en, clk_err;
  frame_t samp_in, samp_out;
  logic [NCH-1:0] mute_stat;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  zm_automute_top u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .samp_in(samp_in),
    .mute_req(mute_req), .auto_en(auto_en), .clk_err(clk_err),
    .samp_out(samp_out), .mute_stat(mute_stat)
  );

  function automatic frame_t fill(input int v);
    frame_t f;
    for (int i = 0; i < NCH; i++) f[i*W +: W] = W'(v);
    return f;
  endfunction

  function automatic frame_t setch(input frame_t f, input int ch, input int v);
    frame_t r = f;
    r[ch*W +: W] = W'(v);
    return r;
  endfunction

  function automatic frame_t mask_out(input frame_t f, input logic [NCH-1:0] m);
    frame_t r = f;
    for (int i = 0; i < NCH; i++) if (m[i]) r[i*W +: W] = '0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [NCH-1:0] exp_stat, input frame_t exp_out);
    n_tests++;
    if (mute_stat !== exp_stat || samp_out !== exp_out) begin
      n_fail++;
      $display("FAIL %s: stat=%h exp=%h out=%h exp=%h", tag, mute_stat, exp_stat,
               samp_out, exp_out);
    end
  endtask

  task automatic put(input frame_t f);
    @(negedge clk);
    samp_in   = f;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; frame_stb = 1'b0; samp_in = '0;
    mute_req = 1'b0; auto_en = 1'b1; clk_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 reset state", 6'h00, '0);
  endtask

  task automatic t_pass();
    frame_t f = '0;
    do_reset();
    for (int i = 0; i < NCH; i++) f = setch(f, i, (i % 2 == 0) ? 1000 * (i + 1) : -3 * (i + 1));
    put(f);
    chk("R10 passthrough", 6'h00, f);
  endtask

  task automatic t_auto();
    frame_t f = '0;
    frame_t g;
    do_reset();
    for (int k = 0; k < 511; k++) begin
      for (int i = 0; i < NCH; i++) f = setch(f, i, ((i + k) % 2 == 0) ? 0 : -1);
      put(f);
    end
    chk("R1/R3 511 silent frames not muted", 6'h00, f);
    put(fill(0));
    chk("R3 512th silent frame mutes", 6'h3F, '0);
    g = setch(fill(0), 3, 5);
    put(g);
    chk("R4 active sample unmutes", 6'h00, g);
    for (int k = 0; k < 511; k++) put(fill(-1));
    chk("R4 run restarts after active frame", 6'h00, fill(-1));
    put(fill(-1));
    chk("R4 fresh run of 512 mutes again", 6'h3F, '0);
  endtask

  task automatic t_partial();
    int seen = 0;
    frame_t f = setch(fill(0), 5, -2);
    do_reset();
    for (int k = 0; k < 600; k++) begin
      put(f);
      if (mute_stat != 0) seen++;
    end
    chk("R2 one active channel blocks auto-mute", 6'h00, f);
    n_tests++;
    if (seen != 0) begin
      n_fail++;
      $display("FAIL R2 muted frames=%0d exp=0", seen);
    end
  endtask

  task automatic t_disable();
    int seen = 0;
    do_reset();
    auto_en = 1'b0;
    for (int k = 0; k < 600; k++) begin
      put(fill(0));
      if (mute_stat != 0) seen++;
    end
    n_tests++;
    if (seen != 0) begin
      n_fail++;
      $display("FAIL R5 muted frames while disabled=%0d exp=0", seen);
    end
    auto_en = 1'b1;
    #1;
    chk("R5 enable acts on existing run", 6'h3F, '0);
    @(negedge clk);
    auto_en = 1'b0;
    #1;
    chk("R5 disable unmutes at once", 6'h00, fill(0));
  endtask

  task automatic t_clkerr();
    frame_t f = fill(1234);
    do_reset();
    put(f);
    clk_err = 1'b1;
    #1;
    chk("R6 clock error mutes without strobe", 6'h3F, '0);
    @(negedge clk);
    clk_err = 1'b0;
    #1;
    chk("R6 clock error release", 6'h00, f);
  endtask

  task automatic t_cross();
    frame_t f;
    do_reset();
    put(fill(100));
    mute_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 request waits for strobe", 6'h00, fill(100));
    put(fill(50));
    chk("R7 no crossing keeps pending", 6'h00, fill(50));
    f = fill(60);
    for (int i = 0; i < 3; i++) f = setch(f, i, -50);
    f = setch(f, 3, 0);
    put(f);
    chk("R7 sign flip and zero apply mute", 6'h0F, mask_out(f, 6'h0F));
    put(fill(70));
    chk("R7 no crossing on ch4/ch5", 6'h0F, mask_out(fill(70), 6'h0F));
  endtask

  task automatic t_timeout();
    do_reset();
    put(fill(100));
    mute_req = 1'b1;
    for (int k = 0; k < 1023; k++) put(fill(100));
    chk("R8 not applied at 1023 pending frames", 6'h00, fill(100));
    put(fill(100));
    chk("R8 applied at 1024th pending frame", 6'h3F, '0);
    mute_req = 1'b0;
    put(fill(100));
    chk("R9 release waits for crossing", 6'h3F, '0);
    put(fill(-100));
    chk("R9 release on crossing", 6'h00, fill(-100));
  endtask

  task automatic t_same_frame();
    frame_t f;
    do_reset();
    mute_req = 1'b1;
    for (int k = 0; k < 512; k++) put(fill(0));
    chk("R3 auto plus request muted", 6'h3F, '0);
    mute_req = 1'b0;
    f = setch(fill(9), 0, -9);
    put(f);
    chk("R10 auto clear with ch0 release same frame", 6'h01 ^ 6'h3F, mask_out(f, 6'h3E));
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; frame_stb = 1'b0; samp_in = '0;
    mute_req = 1'b0; auto_en = 1'b1; clk_err = 1'b0;
    t_reset();
    t_pass();
    t_auto();
    t_partial();
    t_disable();
    t_clkerr();
    t_cross();
    t_timeout();
    t_same_frame();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule